// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

The block keeps a small character store of up to sixteen bytes and refreshes a time-multiplexed display from it. A free-running scan counter steps through the digit positions. At each step the byte held at the current position is presented as two 4-bit nibbles, together with the position index, so the same scan lines can also serve a keyboard matrix elsewhere on the chip. Segment decoding and pin drive are left to downstream logic.

A host loads and reads the store over a byte-wide port. A qualifier bit marks each byte as a command or as data. Commands do the following:
- select the digit count and the entry style;
- load the access pointer and its auto-increment flag;
- set the per-nibble write-inhibit and blanking masks;
- fill the whole store with the blank code.

In left entry, a data byte goes to the pointed location. In right entry, every data byte enters at the last position and the older characters move one place towards position 0.

Top module: `disp_refresh`

## Requirements
- R1: After reset every store location holds 8'hFF, the mode is 8 digits with left entry, the pointer is 0, auto-increment is off, both masks are clear and the scan index is 0.
- R2: A command byte with bits[7:5]=001 loads the mode from bits[1:0]: 00 = 8 digits left entry, 01 = 16 digits left entry, 10 = 8 digits right entry, 11 = 16 digits right entry. It also returns the pointer to 0.
- R3: In left entry, a data write stores the byte at the pointer. `rdData` always shows the byte at the pointer.
- R4: In right entry, a data write moves position i+1 into position i for every i below the last position. The new byte goes to the last position (7 or 15). The pointer is unchanged.
- R5: A command with bits[7:5]=100 sets the write inhibit from bits[3:2] (bit3 = high nibble, bit2 = low nibble). An inhibited nibble of the target location keeps its old value when data is written.
- R6: The same command sets the blanking from bits[1:0] (bit1 = high nibble, bit0 = low nibble). A blanked nibble output shows 4'hF whatever the store holds.
- R7: Commands with bits[7:5]=010 or 011 load the pointer from bits[3:0] and the auto-increment flag from bit4. When the flag is set, the pointer advances after a left-entry data write, or after a read strobe that has no write in the same cycle. When the flag is clear, the pointer does not move.
- R8: The pointer wraps from the last position (7 or 15) to 0. In 8-digit mode, address bit 3 of a pointer load is ignored.
- R9: The scan index advances every SCAN_DIV clocks and wraps to 0 after the last digit of the current size. The nibble outputs show the store byte at the scan index.
- R10: In the first clock of every scan step, `blankStrobe` is high and both nibble outputs are 4'hF.
- R11: A command with bits[7:5]=101 writes 8'hFF to every location, regardless of the inhibit mask. Other opcodes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Byte write strobe |
| hostRd | input | 1 | Read strobe (advances the pointer when auto-increment is on) |
| isCmd | input | 1 | 1 = the byte is a command, 0 = the byte is data |
| hostData | input | 8 | Command or data byte |
| rdData | output | 8 | Store byte at the pointer |
| dispHi | output | 4 | High nibble of the current digit |
| dispLo | output | 4 | Low nibble of the current digit |
| blankStrobe | output | 1 | High in the inter-digit blanking clock |
| scanIdx | output | $clog2(DIGITS_MAX) | Current scan position |

## Verification
A host write can land on the very location that the refresh is showing in that cycle. A right-entry shift can also move every character while a digit is on screen. The bench drives writes, shifts and clears at every phase of the scan divider. These include writes aimed at the current scan position, writes just before a step, and mode changes from 16 to 8 digits while the index sits above 7. A behavioural model predicts the nibble outputs on every clock, so that the new byte is shown from the clock after the write and never a mix of old and new.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_MODE = 3'b001,
    OP_WSET = 3'b010,
    OP_RSET = 3'b011,
    OP_MASK = 3'b100,
    OP_CLR  = 3'b101
  } opcode_e;

  typedef struct packed {
    logic wrEn;
    logic shiftEn;
    logic clearAll;
    logic keepHi;
    logic keepLo;
  } dispStrb_t;
endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl import disp_pkg::*; #(
  parameter int DIGITS_MAX = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostWr,
  input  logic                          hostRd,
  input  logic                          isCmd,
  input  logic [BYTE_W-1:0]             hostData,
  output dispStrb_t                     strb,
  output logic [$clog2(DIGITS_MAX)-1:0] ptr,
  output logic                          wide,
  output logic                          blankHi,
  output logic                          blankLo
);
  localparam int AW = $clog2(DIGITS_MAX);

  logic [1:0]    modeR;
  logic [AW-1:0] ptrR, ptrNext, lastIdx, loadAddr;
  logic          autoR;
  logic [1:0]    inhR, blkR;
  logic          cmdWr, datWr, advance, rightEntry;
  opcode_e       op;

  always_comb begin
    op         = opcode_e'(hostData[7:5]);
    cmdWr      = hostWr & isCmd;
    datWr      = hostWr & ~isCmd;
    rightEntry = modeR[1];
    lastIdx    = modeR[0] ? AW'(DIGITS_MAX - 1) : AW'(DIGITS_MAX / 2 - 1);
    loadAddr   = hostData[AW-1:0] & lastIdx;
    advance    = autoR & ((datWr & ~rightEntry) | (hostRd & ~hostWr));
    ptrNext    = (ptrR == lastIdx) ? '0 : ptrR + 1'b1;

    strb.wrEn     = datWr & ~rightEntry;
    strb.shiftEn  = datWr & rightEntry;
    strb.clearAll = cmdWr && (op == OP_CLR);
    strb.keepHi   = inhR[1];
    strb.keepLo   = inhR[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR <= 2'b00;
      ptrR  <= '0;
      autoR <= 1'b0;
      inhR  <= 2'b00;
      blkR  <= 2'b00;
    end else if (cmdWr) begin
      case (op)
        OP_MODE: begin
          modeR <= hostData[1:0];
          ptrR  <= '0;
        end
        OP_WSET, OP_RSET: begin
          ptrR  <= loadAddr;
          autoR <= hostData[4];
        end
        OP_MASK: begin
          inhR <= hostData[3:2];
          blkR <= hostData[1:0];
        end
        default: ;
      endcase
    end else if (advance) begin
      ptrR <= ptrNext;
    end
  end

  assign ptr     = ptrR;
  assign wide    = modeR[0];
  assign blankHi = blkR[1];
  assign blankLo = blkR[0];

  // R8: pointer never leaves the active digit range
  p_ptr_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    ptrR <= lastIdx);

  // R7: without auto-increment and without a command the pointer holds
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!autoR && !cmdWr) |=> $stable(ptrR));

  // R2: a mode command returns the pointer to zero
  p_mode_ptr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && op == OP_MODE) |=> (ptrR == '0));
endmodule

// File: rtl/disp_data.sv
module disp_data import disp_pkg::*; #(
  parameter int DIGITS_MAX = 16,
  parameter int SCAN_DIV   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dispStrb_t                     strb,
  input  logic [BYTE_W-1:0]             wrData,
  input  logic [$clog2(DIGITS_MAX)-1:0] ptr,
  input  logic                          wide,
  input  logic                          blankHi,
  input  logic                          blankLo,
  output logic [BYTE_W-1:0]             rdData,
  output logic [NIB_W-1:0]              dispHi,
  output logic [NIB_W-1:0]              dispLo,
  output logic                          blankStrobe,
  output logic [$clog2(DIGITS_MAX)-1:0] scanIdx
);
  localparam int AW = $clog2(DIGITS_MAX);
  localparam int DW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [BYTE_W-1:0] BLANK = '1;

  logic [BYTE_W-1:0] mem [DIGITS_MAX];
  logic [AW-1:0]     lastIdx, scanR;
  logic [DW-1:0]     divCnt;
  logic              stepEnd, gap;
  logic [BYTE_W-1:0] cur;

  function automatic logic [BYTE_W-1:0] mergeByte(
    input logic [BYTE_W-1:0] oldB, input logic [BYTE_W-1:0] newB,
    input logic keepH, input logic keepL);
    mergeByte = {keepH ? oldB[7:4] : newB[7:4], keepL ? oldB[3:0] : newB[3:0]};
  endfunction

  assign lastIdx = wide ? AW'(DIGITS_MAX - 1) : AW'(DIGITS_MAX / 2 - 1);
  assign stepEnd = (divCnt == DW'(SCAN_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DIGITS_MAX; i++) mem[i] <= BLANK;
    end else if (strb.clearAll) begin
      for (int i = 0; i < DIGITS_MAX; i++) mem[i] <= BLANK;
    end else if (strb.wrEn) begin
      mem[ptr] <= mergeByte(mem[ptr], wrData, strb.keepHi, strb.keepLo);
    end else if (strb.shiftEn) begin
      for (int i = 0; i < DIGITS_MAX - 1; i++)
        if (AW'(i) < lastIdx) mem[i] <= mem[i+1];
      mem[lastIdx] <= mergeByte(mem[lastIdx], wrData, strb.keepHi, strb.keepLo);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      scanR  <= '0;
    end else if (stepEnd) begin
      divCnt <= '0;
      scanR  <= (scanR >= lastIdx) ? '0 : scanR + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    gap    = (divCnt == '0);
    cur    = mem[scanR];
    dispHi = (gap | blankHi) ? 4'hF : cur[7:4];
    dispLo = (gap | blankLo) ? 4'hF : cur[3:0];
  end

  assign blankStrobe = gap;
  assign scanIdx     = scanR;
  assign rdData      = mem[ptr];

  // R9: the scan index moves only at the end of a divider period
  p_scan_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (scanR != $past(scanR)) |-> ($past(divCnt) == DW'(SCAN_DIV - 1)));

  // R10: every scan change opens with a blanking clock
  p_gap_on_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (scanR != $past(scanR)) |-> (blankStrobe && dispHi == 4'hF && dispLo == 4'hF));

  // R11: a clear leaves the blank code at both ends of the store
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (mem[0] == BLANK && mem[DIGITS_MAX-1] == BLANK));

  // R5: an inhibited high nibble survives a left-entry write
  p_inhibit_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.keepHi) |=> (mem[$past(ptr)][7:4] == $past(mem[ptr][7:4])));

  // R4: a right-entry write moves position 1 into position 0
  p_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftEn && !strb.clearAll) |=> (mem[0] == $past(mem[1])));
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh import disp_pkg::*; #(
  parameter int DIGITS_MAX = 16,
  parameter int SCAN_DIV   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostWr,
  input  logic                          hostRd,
  input  logic                          isCmd,
  input  logic [7:0]                    hostData,
  output logic [7:0]                    rdData,
  output logic [3:0]                    dispHi,
  output logic [3:0]                    dispLo,
  output logic                          blankStrobe,
  output logic [$clog2(DIGITS_MAX)-1:0] scanIdx
);
  localparam int AW = $clog2(DIGITS_MAX);

  dispStrb_t     strb;
  logic [AW-1:0] ptr;
  logic          wide, blankHi, blankLo;

  disp_ctrl #(.DIGITS_MAX(DIGITS_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .isCmd(isCmd),
    .hostData(hostData), .strb(strb), .ptr(ptr), .wide(wide),
    .blankHi(blankHi), .blankLo(blankLo)
  );

  disp_data #(.DIGITS_MAX(DIGITS_MAX), .SCAN_DIV(SCAN_DIV)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(hostData), .ptr(ptr),
    .wide(wide), .blankHi(blankHi), .blankLo(blankLo), .rdData(rdData),
    .dispHi(dispHi), .dispLo(dispLo), .blankStrobe(blankStrobe), .scanIdx(scanIdx)
  );
endmodule

// File: tb/tb_disp_refresh.sv
module tb_disp_refresh;
  localparam int DIGITS_MAX = 16;
  localparam int SCAN_DIV   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0, isCmd = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic [7:0] rdData;
  logic [3:0] dispHi, dispLo;
  logic       blankStrobe;
  logic [3:0] scanIdx;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  int m[16];
  int mMode, mPtr, mAuto, mInh, mBlk, mDiv, mScan;

  always #2 clk = ~clk;

  disp_refresh #(.DIGITS_MAX(DIGITS_MAX), .SCAN_DIV(SCAN_DIV)) dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .isCmd(isCmd),
    .hostData(hostData), .rdData(rdData), .dispHi(dispHi), .dispLo(dispLo),
    .blankStrobe(blankStrobe), .scanIdx(scanIdx)
  );

  function automatic int lastOf(int mode);
    return (mode & 1) ? 15 : 7;
  endfunction

  function automatic int merged(int oldB, int newB, int inh);
    int hi, lo;
    hi = (inh & 2) ? (oldB & 8'hF0) : (newB & 8'hF0);
    lo = (inh & 1) ? (oldB & 8'h0F) : (newB & 8'h0F);
    return hi | lo;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) m[i] = 8'hFF;
    mMode = 0; mPtr = 0; mAuto = 0; mInh = 0; mBlk = 0; mDiv = 0; mScan = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    int last, op, d;
    int nm[16];
    cycles++;
    if (!rstN) modelReset();
    else begin
      last = lastOf(mMode);
      d = int'(hostData);
      op = d >> 5;
      for (int i = 0; i < 16; i++) nm[i] = m[i];
      if (mDiv == SCAN_DIV - 1) begin
        mDiv = 0;
        mScan = (mScan >= last) ? 0 : mScan + 1;
      end else mDiv++;
      if (hostWr && isCmd) begin
        if (op == 1) begin mMode = d & 3; mPtr = 0; end
        else if (op == 2 || op == 3) begin mPtr = (d & 15) & last; mAuto = (d >> 4) & 1; end
        else if (op == 4) begin mInh = (d >> 2) & 3; mBlk = d & 3; end
        else if (op == 5) for (int i = 0; i < 16; i++) nm[i] = 8'hFF;
      end else if (hostWr) begin
        if (mMode & 2) begin
          for (int i = 0; i < last; i++) nm[i] = m[i+1];
          nm[last] = merged(m[last], d, mInh);
        end else begin
          nm[mPtr] = merged(m[mPtr], d, mInh);
          if (mAuto) mPtr = (mPtr == last) ? 0 : mPtr + 1;
        end
      end else if (hostRd && mAuto) begin
        mPtr = (mPtr == last) ? 0 : mPtr + 1;
      end
      for (int i = 0; i < 16; i++) m[i] = nm[i];
    end
  end

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, got, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!finished) begin
      int expHi, expLo;
      bit gap;
      gap = (mDiv == 0);
      expHi = (gap || (mBlk & 2)) ? 15 : (m[mScan] >> 4) & 15;
      expLo = (gap || (mBlk & 1)) ? 15 : m[mScan] & 15;
      chk(rstN ? "R9 scanIdx" : "R1 scanIdx", int'(scanIdx), mScan);
      chk("R10 blankStrobe", int'(blankStrobe), int'(gap));
      chk("R6 dispHi", int'(dispHi), expHi);
      chk("R6 dispLo", int'(dispLo), expLo);
      chk(rstN ? "R3 rdData" : "R1 rdData", int'(rdData), m[mPtr]);
    end
  end

  task automatic drive(bit wr, bit rd, bit cmd, logic [7:0] d);
    @(negedge clk);
    hostWr = wr; hostRd = rd; isCmd = cmd; hostData = d;
  endtask
  task automatic cmdB(logic [7:0] d); drive(1, 0, 1, d); endtask
  task automatic datB(logic [7:0] d); drive(1, 0, 0, d); endtask
  task automatic rdS(); drive(0, 1, 0, 8'h00); endtask
  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00);
  endtask

  task automatic finish();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle();
    chk("R1 reset rdData", int'(rdData), 8'hFF);
    idle(40);                                // R9 wrap at 8 digits
    cmdB(8'h50);                             // R7 write setup addr 0, auto
    for (int i = 1; i <= 9; i++) datB(8'(i));
    cmdB(8'h60); idle();
    chk("R8 wrap wrote loc0", int'(rdData), 8'h09);
    cmdB(8'h61); idle();
    chk("R3 loc1", int'(rdData), 8'h02);
    cmdB(8'h73); idle();
    chk("R7 read auto start", int'(rdData), 8'h04);
    rdS(); idle();
    chk("R7 read advanced", int'(rdData), 8'h05);
    cmdB(8'h88); cmdB(8'h42); datB(8'hAB); idle();
    chk("R5 inhibit hi", int'(rdData), 8'h0B);
    datB(8'hCD); idle();
    chk("R7 no advance", int'(rdData), 8'h0D);
    cmdB(8'h80);
    cmdB(8'h82); idle(2);
    while (blankStrobe) idle();
    chk("R6 blank hi", int'(dispHi), 4'hF);
    idle(12);
    cmdB(8'h80);
    cmdB(8'h22); datB(8'h11); datB(8'h22);   // R4 right entry, 8 digits
    cmdB(8'h67); idle();
    chk("R4 last pos", int'(rdData), 8'h22);
    cmdB(8'h66); idle();
    chk("R4 shifted", int'(rdData), 8'h11);
    cmdB(8'h21); cmdB(8'h4F); datB(8'h5A);   // R2 16 digits left entry
    cmdB(8'h6F); idle();
    chk("R2 16-digit loc15", int'(rdData), 8'h5A);
    idle(70);
    cmdB(8'h20); cmdB(8'h6F); idle();
    chk("R8 masked addr", int'(rdData), 8'h22);
    idle(40);
    cmdB(8'h23); cmdB(8'h84);
    for (int i = 0; i < 5; i++) datB(8'(8'h30 + i));
    cmdB(8'h80); idle(30);
    cmdB(8'hA0); idle();                     // R11 clear
    chk("R11 clear", int'(rdData), 8'hFF);
    cmdB(8'h21); cmdB(8'h6F); idle();
    chk("R11 clear loc15", int'(rdData), 8'hFF);
    cmdB(8'hE5); cmdB(8'h1F); idle();        // R11 undefined opcodes do nothing
    chk("R11 no-op", int'(rdData), 8'hFF);
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 12;
      case (r)
        0, 1, 2: datB(8'($urandom));
        3: rdS();
        4: cmdB({6'b001000, 2'($urandom)});
        5: cmdB({2'b01, 6'($urandom)});
        6: cmdB({4'b1000, 4'($urandom)});
        7: if ($urandom % 6 == 0) cmdB(8'hA0); else idle();
        8: cmdB({3'b000, 5'($urandom)});
        9: drive(1, 1, 0, 8'($urandom));
        default: idle();
      endcase
    end
    idle(4);
    finish();
  end
endmodule